// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects twelve interrupt sources and presents one request at a time to a program sequencer. The request comes with the source number and a fixed vector address. Source 0 is a system reset request and source 1 is a power-down request; neither can be masked. The other ten sources pass through a mask register. Some sources are always captured on a rising edge. Some are always sampled as levels. Three can be switched between the two styles by a control register.

Software controls the block through single-cycle write strobes. These write the mask, the control register (edge selects and nesting), the force/clear register for edge latches, and the global enable. The sequencer acknowledges a request with `irq_ack` and signals the end of a handler with `irq_ret`. In nested mode a request is offered only if it outranks every handler still in service. In sequential mode nothing is offered while any handler is in service.

Top module: `vic_ctrl`

## Requirements
- R1: The sources have a fixed order of priority, with index 0 highest and index 11 lowest. When `irq_req` is high, `irq_id` names the highest-priority eligible source and `irq_vec` holds its vector: 0x0000 for index 0, 0x002C for index 1, and 4*(index-1) for indexes 2 to 11 (0x0004 up to 0x0028). When `irq_req` is low, both outputs read zero.
- R2: Sources 1, 5, 6, 7, 8 and 11 are edge-captured. A rising edge sets a pending latch, which stays set after the input falls and is cleared when that source's request is acknowledged.
- R3: Sources 0, 3 and 4 are level-sampled. One cycle after the input rises they are pending, and they stop being pending one cycle after it falls. Nothing is remembered.
- R4: `ctl_wdata` bits 0, 1 and 2 select edge capture (1) or level sampling (0) for sources 2, 9 and 10 in that order. All three are level-sampled after reset.
- R5: Mask bit i set to 1 lets source i (i from 2 to 11) request. Mask bits 0 and 1 have no effect, so sources 0 and 1 are never masked. The mask is all zero after reset.
- R6: In the cycle after any mask write, no request other than source 0 is offered.
- R7: A force write (`frc_wr`) sets the edge latches named in `frc_set` and clears those named in `frc_clr`. Clear wins when a bit is named in both. The write has no effect on sources that are currently level-sampled.
- R8: The global enable is on after reset. `gie_clr` turns it off and `gie_set` turns it on, with clear winning when both are pulsed together. While the enable is off, only source 0 can request.
- R9: With `ctl_wdata` bit 3 at 1 (nested mode), a request is offered only if its index is lower than the lowest index in service. `irq_ret` ends the highest-priority handler in service.
- R10: With `ctl_wdata` bit 3 at 0 (sequential mode), no request other than source 0 is offered while any handler is in service.
- R11: A pending source 0 request is offered regardless of mask, global enable, lockout and handlers in service.
- R12: `irq_ack` while `irq_req` is low changes neither the handlers in service nor any latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 12 | Raw interrupt source lines, index 0 highest priority |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 12 | New mask value, 1 enables a source |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Bits 2:0 edge select for sources 2, 9, 10; bit 3 nested mode |
| frc_wr | input | 1 | Force/clear write strobe |
| frc_set | input | 12 | Edge latches to set |
| frc_clr | input | 12 | Edge latches to clear |
| gie_set | input | 1 | Global enable on |
| gie_clr | input | 1 | Global enable off |
| irq_ack | input | 1 | Sequencer takes the offered request |
| irq_ret | input | 1 | Handler return |
| irq_req | output | 1 | A request is offered |
| irq_id | output | 4 | Index of the offered source |
| irq_vec | output | 14 | Vector address of the offered source |

## Verification
The bench tries the block with several kinds of input. A lone level pulse and a lone edge pulse show the difference between sampling and latching. Several edges arriving with a held level show the priority order and the vector map. Masked and unmasked copies of the same edge separate the power-down path from the masked path. Mask writes made while a request waits expose the one-cycle lockout. Force writes aimed at level-sampled sources, and writes that set and clear the same bit, test the precedence rules. Chains of acknowledge and return in both servicing modes separate preemption from queuing. An acknowledge with nothing offered must leave no trace.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC      = 12;
  localparam int ID_W      = $clog2(NSRC);
  localparam int VEC_W     = 14;
  localparam int CFG_N     = 3;
  localparam int CTL_W     = CFG_N + 1;
  localparam int NEST_BIT  = CFG_N;
  localparam int VEC_STEP  = 4;
  localparam int PWRDN_VEC = 44;

  typedef enum logic [1:0] {
    SK_LEVEL = 2'd0,
    SK_EDGE  = 2'd1,
    SK_CFG   = 2'd2
  } sense_e;

  // capture style of each source index
  function automatic sense_e sense_of(input int idx);
    case (idx)
      0, 3, 4:  return SK_LEVEL;
      2, 9, 10: return SK_CFG;
      default:  return SK_EDGE;
    endcase
  endfunction

  // control bit that selects edge capture for a configurable source
  function automatic int cfg_slot(input int idx);
    case (idx)
      9:       return 1;
      10:      return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_maskable(input int idx);
    return idx >= 2;
  endfunction

  // vector address of a source index
  function automatic logic [VEC_W-1:0] vec_of(input logic [ID_W-1:0] id);
    logic [VEC_W-1:0] v;
    if (id == ID_W'(0))      v = '0;
    else if (id == ID_W'(1)) v = VEC_W'(PWRDN_VEC);
    else                     v = VEC_W'(id - ID_W'(1)) * VEC_W'(VEC_STEP);
    return v;
  endfunction

  // index of the lowest set bit (highest priority), zero when none
  function automatic logic [ID_W-1:0] lowest_set(input logic [NSRC-1:0] bits);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (bits[i]) r = ID_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic edge_mode,
  input  logic ack_hit,
  input  logic frc_set,
  input  logic frc_clr,
  output logic pending
);
  logic samp_q;
  logic latch_q;
  logic latch_d;
  logic rise;

  assign rise = src_in & ~samp_q;

  always_comb begin
    latch_d = latch_q;
    if (ack_hit)          latch_d = 1'b0;
    if (rise || frc_set)  latch_d = 1'b1;
    if (frc_clr)          latch_d = 1'b0;
    if (!edge_mode)       latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      samp_q  <= src_in;
      latch_q <= latch_d;
    end
  end

  assign pending = edge_mode ? latch_q : samp_q;
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] id,
  output logic [N-1:0]  grant
);
  assign any   = |req;
  assign grant = req & (~req + N'(1));

  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = IW'(i);
    end
  end
endmodule

// File: rtl/vic_svc_track.sv
module vic_svc_track #(
  parameter int N  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] take_id,
  input  logic          ret,
  output logic          busy,
  output logic [IW-1:0] top_id,
  output logic [N-1:0]  svc_vec
);
  logic [N-1:0] svc_q;
  logic [N-1:0] svc_d;
  logic [N-1:0] top_bit;

  assign top_bit = svc_q & (~svc_q + N'(1));

  always_comb begin
    svc_d = svc_q;
    if (ret)  svc_d = svc_d & ~top_bit;
    if (take) svc_d = svc_d | (N'(1) << take_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  always_comb begin
    top_id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (svc_q[i]) top_id = IW'(i);
    end
  end

  assign busy    = |svc_q;
  assign svc_vec = svc_q;
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             mask_wr,
  input  logic [NSRC-1:0]  mask_wdata,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             frc_wr,
  input  logic [NSRC-1:0]  frc_set,
  input  logic [NSRC-1:0]  frc_clr,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [ID_W-1:0]  irq_id,
  output logic [VEC_W-1:0] irq_vec
);
  localparam logic [NSRC-1:0] RST_BIT  = NSRC'(1);
  localparam logic [NSRC-1:0] NORM_SET = ~RST_BIT;

  logic [NSRC-1:0]  mask_q;
  logic             gie_q;
  logic             lock_q;
  logic [CTL_W-1:0] ctl_q;
  logic             nest_q;

  logic [NSRC-1:0]  edge_mode;
  logic [NSRC-1:0]  mask_eff;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  ack_hit;
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  frc_set_w;
  logic [NSRC-1:0]  frc_clr_w;

  logic             cand_any;
  logic [ID_W-1:0]  cand_id;
  logic [NSRC-1:0]  cand_grant;

  logic             busy;
  logic [ID_W-1:0]  top_id;
  logic [NSRC-1:0]  svc_vec;

  logic             rst_pend;
  logic             allow;
  logic             norm_ok;
  logic             take;
  logic [NSRC-1:0]  grant;

  // software-visible control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b1;
      lock_q <= 1'b0;
      ctl_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      lock_q <= mask_wr;
      if (gie_clr)      gie_q <= 1'b0;
      else if (gie_set) gie_q <= 1'b1;
      if (ctl_wr) ctl_q <= ctl_wdata;
    end
  end

  assign nest_q    = ctl_q[NEST_BIT];
  assign frc_set_w = frc_set & {NSRC{frc_wr}};
  assign frc_clr_w = frc_clr & {NSRC{frc_wr}};
  assign take      = irq_ack & irq_req;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam sense_e SK = sense_of(i);
    if (SK == SK_EDGE) begin : g_edge
      assign edge_mode[i] = 1'b1;
    end else if (SK == SK_CFG) begin : g_cfg
      assign edge_mode[i] = ctl_q[cfg_slot(i)];
    end else begin : g_level
      assign edge_mode[i] = 1'b0;
    end

    assign mask_eff[i] = mask_q[i] | !is_maskable(i);
    assign ack_hit[i]  = take && (irq_id == ID_W'(i));

    vic_src_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in[i]),
      .edge_mode (edge_mode[i]),
      .ack_hit   (ack_hit[i]),
      .frc_set   (frc_set_w[i]),
      .frc_clr   (frc_clr_w[i]),
      .pending   (pend[i])
    );
  end

  assign rst_pend = pend[0];
  assign elig     = pend & mask_eff & NORM_SET;

  vic_prio_pick #(.N(NSRC), .IW(ID_W)) u_pick (
    .req   (elig),
    .any   (cand_any),
    .id    (cand_id),
    .grant (cand_grant)
  );

  vic_svc_track #(.N(NSRC), .IW(ID_W)) u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_id (irq_id),
    .ret     (irq_ret),
    .busy    (busy),
    .top_id  (top_id),
    .svc_vec (svc_vec)
  );

  assign allow   = !busy || (nest_q && (cand_id < top_id));
  assign norm_ok = cand_any && gie_q && !lock_q && allow;
  assign irq_req = rst_pend || norm_ok;

  always_comb begin
    if (rst_pend) begin
      irq_id = '0;
      grant  = RST_BIT;
    end else if (norm_ok) begin
      irq_id = cand_id;
      grant  = cand_grant;
    end else begin
      irq_id = '0;
      grant  = '0;
    end
  end

  assign irq_vec = vec_of(irq_id);
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk
  import vic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            mask_wr,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic            irq_req,
  input logic [ID_W-1:0] irq_id,
  input logic            gie_q,
  input logic            nest_q,
  input logic            rst_pend,
  input logic            busy,
  input logic [ID_W-1:0] top_id,
  input logic [NSRC-1:0] grant,
  input logic [NSRC-1:0] svc_vec
);
  // R1
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (irq_req == (grant != '0)));

  // R6
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (rst_pend || !irq_req));

  // R8
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !rst_pend) |-> !irq_req);

  // R9
  nest_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_q && busy && irq_req && !rst_pend) |-> (irq_id < top_id));

  // R10
  seq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_q && busy && !rst_pend) |-> !irq_req);

  // R11
  rst_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend |-> (irq_req && irq_id == '0));

  // R12
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !irq_ret) |=> (svc_vec == $past(svc_vec)));
endmodule

bind vic_ctrl vic_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mask_wr  (mask_wr),
  .irq_ack  (irq_ack),
  .irq_ret  (irq_ret),
  .irq_req  (irq_req),
  .irq_id   (irq_id),
  .gie_q    (gie_q),
  .nest_q   (nest_q),
  .rst_pend (rst_pend),
  .busy     (busy),
  .top_id   (top_id),
  .grant    (grant),
  .svc_vec  (svc_vec)
);

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src_in = '0;
  logic        mask_wr = 1'b0;
  logic [11:0] mask_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [3:0]  ctl_wdata = '0;
  logic        frc_wr = 1'b0;
  logic [11:0] frc_set = '0;
  logic [11:0] frc_clr = '0;
  logic        gie_set = 1'b0;
  logic        gie_clr = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_id;
  logic [13:0] irq_vec;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  bit    armed = 0;
  string phase = "R8";

  always #5 clk = ~clk;

  vic_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .frc_wr(frc_wr), .frc_set(frc_set), .frc_clr(frc_clr),
    .gie_set(gie_set), .gie_clr(gie_clr),
    .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec)
  );

  // ---------------- behavioural reference model ----------------
  logic [11:0] m_latch, m_samp, m_mask, m_svc;
  logic        m_gie, m_lock;
  logic [3:0]  m_ctl;

  function automatic bit b_edge(int i);
    case (i)
      0, 3, 4: return 1'b0;
      2:       return m_ctl[0];
      9:       return m_ctl[1];
      10:      return m_ctl[2];
      default: return 1'b1;
    endcase
  endfunction

  function automatic int b_vec(int i);
    case (i)
      0: return 'h00;  1: return 'h2C;  2: return 'h04;  3: return 'h08;
      4: return 'h0C;  5: return 'h10;  6: return 'h14;  7: return 'h18;
      8: return 'h1C;  9: return 'h20; 10: return 'h24; 11: return 'h28;
      default: return 0;
    endcase
  endfunction

  function automatic int b_pick();
    int first;
    int top;
    first = -1;
    top = 99;
    if (m_samp[0]) return 0;
    if (!m_gie || m_lock) return -1;
    for (int i = 1; i < 12; i++) begin
      bit p;
      p = b_edge(i) ? m_latch[i] : m_samp[i];
      if (first < 0 && p && (i == 1 || m_mask[i])) first = i;
    end
    if (first < 0) return -1;
    if (m_svc == 0) return first;
    for (int i = 11; i >= 0; i--) if (m_svc[i]) top = i;
    if (m_ctl[3] && first < top) return first;
    return -1;
  endfunction

  always @(posedge clk) begin
    int sel;
    logic [11:0] nl;
    logic [11:0] ns;
    bit popped;
    if (!rst_n) begin
      m_latch = '0; m_samp = '0; m_mask = '0; m_svc = '0;
      m_gie = 1'b1; m_lock = 1'b0; m_ctl = '0;
    end else begin
      sel = b_pick();
      nl = '0;
      for (int i = 0; i < 12; i++) begin
        if (b_edge(i)) begin
          bit l;
          l = m_latch[i];
          if (irq_ack && sel == i) l = 1'b0;
          if ((src_in[i] && !m_samp[i]) || (frc_wr && frc_set[i])) l = 1'b1;
          if (frc_wr && frc_clr[i]) l = 1'b0;
          nl[i] = l;
        end
      end
      ns = m_svc;
      popped = 0;
      if (irq_ret) begin
        for (int i = 0; i < 12; i++) begin
          if (!popped && ns[i]) begin ns[i] = 1'b0; popped = 1; end
        end
      end
      if (irq_ack && sel >= 0) ns[sel] = 1'b1;
      m_latch = nl;
      m_svc = ns;
      m_samp = src_in;
      if (mask_wr) m_mask = mask_wdata;
      m_lock = mask_wr;
      if (gie_clr) m_gie = 1'b0;
      else if (gie_set) m_gie = 1'b1;
      if (ctl_wr) m_ctl = ctl_wdata;
    end
  end

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    int s;
    logic [31:0] er, ei, ev;
    if (armed && !done) begin
      s = b_pick();
      er = (s >= 0) ? 1 : 0;
      ei = (s >= 0) ? s : 0;
      ev = (s >= 0) ? b_vec(s) : 0;
      checks++;
      if (irq_req !== er[0] || irq_id !== ei[3:0] || irq_vec !== ev[13:0]) begin
        failures++;
        $display("FAIL %s model req/id/vec actual=%0b/%0d/%0h expected=%0b/%0d/%0h",
                 phase, irq_req, irq_id, irq_vec, er[0], ei, ev);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic want(string tag, bit req, int id, int vec);
    chk(tag, {31'd0, irq_req}, {31'd0, req}, "irq_req");
    chk(tag, {28'd0, irq_id}, id, "irq_id");
    chk(tag, {18'd0, irq_vec}, vec, "irq_vec");
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quiet();
    mask_wr = 0; ctl_wr = 0; frc_wr = 0; frc_set = '0; frc_clr = '0;
    gie_set = 0; gie_clr = 0; irq_ack = 0; irq_ret = 0;
  endtask

  task automatic ack_ret();
    irq_ack = 1; tick(); quiet();
    irq_ret = 1; tick(); quiet();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    armed = 1;
    rst_n = 1; tick();
    phase = "R8";
    want("R8", 0, 0, 0);                       // reset: nothing offered

    mask_wr = 1; mask_wdata = 12'hFFF; tick(); quiet(); tick();

    phase = "R3";                              // level sampling
    src_in[3] = 1; tick();
    want("R3", 1, 3, 'h08);
    tick();
    src_in[3] = 0; tick();
    want("R3", 0, 0, 0);

    phase = "R2";                              // edge latching
    src_in[7] = 1; tick(); src_in[7] = 0; tick();
    want("R2", 1, 7, 'h18);
    irq_ack = 1; tick(); quiet();
    want("R10", 0, 0, 0);
    irq_ret = 1; tick(); quiet();
    want("R2", 0, 0, 0);                       // latch cleared by ack

    phase = "R12";                             // stray acknowledge
    irq_ack = 1; tick(); quiet();
    src_in[11] = 1; tick(); src_in[11] = 0; tick();
    want("R12", 1, 11, 'h28);
    ack_ret();

    phase = "R1";                              // priority order and vectors
    src_in[5] = 1; src_in[8] = 1; src_in[11] = 1; src_in[4] = 1; tick();
    src_in[5] = 0; src_in[8] = 0; src_in[11] = 0; tick();
    want("R1", 1, 4, 'h0C);
    irq_ack = 1; tick(); quiet();
    want("R10", 0, 0, 0);
    irq_ret = 1; src_in[4] = 0; tick(); quiet();
    want("R1", 1, 5, 'h10);
    ack_ret();
    want("R1", 1, 8, 'h1C);
    ack_ret();
    want("R1", 1, 11, 'h28);
    ack_ret();
    want("R1", 0, 0, 0);

    phase = "R5";                              // masking
    mask_wr = 1; mask_wdata = 12'h000; tick(); quiet(); tick();
    src_in[7] = 1; src_in[1] = 1; tick(); src_in[7] = 0; src_in[1] = 0; tick();
    want("R5", 1, 1, 'h2C);
    ack_ret();
    want("R5", 0, 0, 0);

    phase = "R6";                              // lockout after mask write
    mask_wr = 1; mask_wdata = 12'hFFF; tick(); quiet();
    want("R6", 0, 0, 0);
    tick();
    want("R6", 1, 7, 'h18);
    ack_ret();

    phase = "R7";                              // force and clear
    frc_wr = 1; frc_set[11] = 1; frc_set[3] = 1; frc_set[2] = 1; tick(); quiet();
    want("R7", 1, 11, 'h28);
    frc_wr = 1; frc_clr[11] = 1; tick(); quiet();
    want("R7", 0, 0, 0);
    frc_wr = 1; frc_set[8] = 1; frc_clr[8] = 1; tick(); quiet();
    want("R7", 0, 0, 0);

    phase = "R4";                              // configurable sense
    ctl_wr = 1; ctl_wdata = 4'b0001; tick(); quiet();
    src_in[2] = 1; tick(); src_in[2] = 0; tick();
    want("R4", 1, 2, 'h04);
    ack_ret();
    src_in[9] = 1; tick();
    want("R4", 1, 9, 'h20);
    src_in[9] = 0; tick();
    want("R4", 0, 0, 0);

    phase = "R8";                              // global enable
    gie_clr = 1; tick(); quiet();
    src_in[6] = 1; tick(); src_in[6] = 0; tick();
    want("R8", 0, 0, 0);
    gie_set = 1; gie_clr = 1; tick(); quiet();
    want("R8", 0, 0, 0);
    gie_set = 1; tick(); quiet();
    want("R8", 1, 6, 'h14);
    ack_ret();

    phase = "R9";                              // nested servicing
    ctl_wr = 1; ctl_wdata = 4'b1000; tick(); quiet();
    src_in[11] = 1; tick(); src_in[11] = 0; tick();
    want("R9", 1, 11, 'h28);
    irq_ack = 1; tick(); quiet();
    src_in[5] = 1; tick(); src_in[5] = 0; tick();
    want("R9", 1, 5, 'h10);
    irq_ack = 1; tick(); quiet();
    src_in[8] = 1; tick(); src_in[8] = 0; tick();
    want("R9", 0, 0, 0);
    irq_ret = 1; tick(); quiet();
    want("R9", 1, 8, 'h1C);
    ack_ret();
    want("R9", 0, 0, 0);
    irq_ret = 1; tick(); quiet();
    want("R9", 0, 0, 0);

    phase = "R11";                             // reset source bypass
    src_in[0] = 1; gie_clr = 1; mask_wr = 1; mask_wdata = 12'h000; tick(); quiet();
    want("R11", 1, 0, 'h00);
    irq_ack = 1; tick(); quiet();
    want("R11", 1, 0, 'h00);
    src_in[0] = 0; irq_ret = 1; tick(); quiet();
    want("R11", 0, 0, 0);
    gie_set = 1; tick(); quiet();
    repeat (3) tick();

    done = 1;
    finish_run();
  end
endmodule